// File: doc/BRIEF.md
# Scheduled Buffer Transfer Engine

This block is a small, non-pipelined controller that copies words from a source buffer into a destination buffer. It does not decide when to move data. It follows a stored program whose wait instructions place every read and write on a cycle fixed at compile time. Programs are written into a 32-bit instruction memory through a plain write port while the engine is idle. A single start pulse then runs the program from address zero.

The engine holds sixteen 16-bit registers, which the program loads with immediates. Those registers supply the source address, the destination address and the stride for repeated copies. A program ends with a zero-count wait. That instruction drops `busy` and parks the engine until the next start pulse.

The source buffer is assumed to return read data one cycle after a read is issued. That data passes straight through to the destination write port in that cycle.

Top module: `xfer_engine`

## Requirements
- R1: After reset, `busy`, `src_ren` and `dst_we` are low, and the engine stays idle until a start pulse.
- R2: A start pulse sampled at a clock edge raises `busy` in the next cycle and begins execution at instruction address 0. This happens in every state, so a start during a running program restarts it.
- R3: Instructions use the following fields:
  - [31:28] is the opcode: 0000 wait, 0010 load immediate, 1000 move, 1001 repeated move.
  - [27:24] is the destination register, [23:20] the source register and [19:16] the stride register.
  - [15:0] is the immediate.
  - Any other opcode is skipped and takes two cycles.
- R4: Each instruction spends one fetch cycle and one execute cycle. A wait with immediate n>0 adds exactly n idle cycles before the next fetch.
- R5: A wait with immediate 0 lowers `busy` in the cycle after its execute cycle. No read or write happens after that until the next start pulse.
- R6: Load immediate writes the 16-bit immediate into the destination register. The next instruction can read the new value.
- R7: Register 0 always reads as zero, and any load into it is discarded.
- R8: Move timing is as follows:
  - `src_ren` is high in the cycle after the execute cycle, with `src_raddr` = source register + immediate.
  - One cycle later, `dst_we` is high with `dst_waddr` = destination register + immediate and `dst_wdata` equal to `src_rdata` in that cycle.
  - The next instruction is fetched right after the read cycle.
- R9: Repeated move with count n (the immediate) reads on n consecutive cycles and writes on the n cycles that follow each read by one.
  - Both addresses start at the plain register values and advance by the stride register value after each transfer, wrapping modulo 2^16.
  - The next fetch follows the last read.
  - With n=0, nothing is transferred and the instruction takes two cycles.
- R10: Words written through the instruction write port while idle are executed by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that runs the program from address 0 |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | PC_W | Instruction memory write address |
| imem_wdata | input | 32 | Instruction word to store |
| src_ren | output | 1 | Read strobe to the source buffer |
| src_raddr | output | 16 | Source buffer read address |
| src_rdata | input | DATA_W | Source buffer data, valid one cycle after `src_ren` |
| dst_we | output | 1 | Write strobe to the destination buffer |
| dst_waddr | output | 16 | Destination buffer write address |
| dst_wdata | output | DATA_W | Destination buffer write data |
| busy | output | 1 | High from a start pulse until a zero-count wait executes |

## Verification
The bench runs four programs, each aimed at a different aspect of the engine:
- A single offset move, which separates the register-plus-immediate addressing from the pure register addressing used by repeated moves.
- A counted wait followed by a strided repeated move, in which every write is checked against an exact cycle number. A wrong wait length, a wrong stride or a missing final transfer therefore each show up as distinct mismatches.
- A program that loads register 0, copies with it, issues a zero-count repeat and an unknown opcode, and makes an address wrap past 0xFFFF.
- A long wait interrupted by a second start pulse, which is visible only through the cycle in which `busy` finally falls.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 16;
  localparam int REG_N   = 16;
  localparam int RIDX_W  = $clog2(REG_N);

  typedef enum logic [3:0] {
    OP_WAIT = 4'b0000,
    OP_LDI  = 4'b0010,
    OP_MOV  = 4'b1000,
    OP_MOVC = 4'b1001
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_WAIT, S_MOVE
  } st_e;

  typedef struct packed {
    logic [3:0]        op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [REG_W-1:0]  imm;
  } instr_t;
endpackage

// File: rtl/xfer_imem.sv
module xfer_imem #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
  parameter int N     = 16,
  parameter int AW    = 4,
  parameter int W     = 16,
  parameter int PORTS = 3
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [W-1:0]              wdata,
  input  logic [PORTS-1:0][AW-1:0]  raddr,
  output logic [PORTS-1:0][W-1:0]   rdata
);
  logic [W-1:0] regs [N];

  // index 0 is never stored
  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int PC_W = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  output logic [PC_W-1:0]               imem_raddr,
  input  logic [INSTR_W-1:0]            imem_rdata,
  output logic [2:0][RIDX_W-1:0]        rf_raddr,
  input  logic [2:0][REG_W-1:0]         rf_rdata,
  output logic                          rf_we,
  output logic [RIDX_W-1:0]             rf_waddr,
  output logic [REG_W-1:0]              rf_wdata,
  output logic                          src_ren,
  output logic [REG_W-1:0]              src_raddr,
  output logic                          dst_we,
  output logic [REG_W-1:0]              dst_waddr,
  output logic                          busy
);
  st_e              st;
  logic [PC_W-1:0]  pc;
  logic [REG_W-1:0] cnt;
  logic [REG_W-1:0] dptr;
  logic [REG_W-1:0] stride;
  instr_t           ir;

  assign ir         = instr_t'(imem_rdata);
  assign imem_raddr = pc;
  assign rf_raddr   = {ir.rt, ir.rs, ir.rd};   // port0=rd, 1=rs, 2=rt
  assign rf_we      = (st == S_EXEC) && (op_e'(ir.op) == OP_LDI) && !start;
  assign rf_waddr   = ir.rd;
  assign rf_wdata   = ir.imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; pc <= '0; busy <= 1'b0; cnt <= '0;
      src_ren <= 1'b0; src_raddr <= '0; dptr <= '0; stride <= '0;
      dst_we <= 1'b0; dst_waddr <= '0;
    end else begin
      dst_we    <= src_ren;       // source data arrives one cycle later
      dst_waddr <= dptr;
      src_ren   <= 1'b0;
      if (start) begin
        st <= S_FETCH; pc <= '0; busy <= 1'b1;
      end else begin
        unique case (st)
          S_FETCH: st <= S_EXEC;
          S_EXEC: begin
            case (op_e'(ir.op))
              OP_WAIT: begin
                if (ir.imm == '0) begin
                  st <= S_IDLE; busy <= 1'b0;
                end else begin
                  cnt <= ir.imm; st <= S_WAIT;
                end
              end
              OP_MOV: begin
                src_raddr <= rf_rdata[1] + ir.imm;
                dptr      <= rf_rdata[0] + ir.imm;
                src_ren   <= 1'b1;
                cnt       <= '0;
                st        <= S_MOVE;
              end
              OP_MOVC: begin
                if (ir.imm == '0) begin
                  pc <= pc + 1'b1; st <= S_FETCH;
                end else begin
                  src_raddr <= rf_rdata[1];
                  dptr      <= rf_rdata[0];
                  stride    <= rf_rdata[2];
                  src_ren   <= 1'b1;
                  cnt       <= ir.imm - 1'b1;
                  st        <= S_MOVE;
                end
              end
              default: begin            // load immediate and unused codes
                pc <= pc + 1'b1; st <= S_FETCH;
              end
            endcase
          end
          S_WAIT: begin
            cnt <= cnt - 1'b1;
            if (cnt == 16'd1) begin
              pc <= pc + 1'b1; st <= S_FETCH;
            end
          end
          S_MOVE: begin
            if (cnt != '0) begin
              src_raddr <= src_raddr + stride;
              dptr      <= dptr + stride;
              src_ren   <= 1'b1;
              cnt       <= cnt - 1'b1;
            end else begin
              pc <= pc + 1'b1; st <= S_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && st == S_FETCH && pc == '0));
  // R5
  park_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!busy && !src_ren));
  // R4
  wait_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !start && cnt > 16'd1) |=> (st == S_WAIT && cnt == $past(cnt) - 1'b1));
  // R9
  stride_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_MOVE && cnt != '0 && !start) |=> (src_ren && src_raddr == $past(src_raddr) + $past(stride)));
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int PC_W       = $clog2(IMEM_DEPTH),
  parameter int DATA_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               imem_we,
  input  logic [PC_W-1:0]    imem_waddr,
  input  logic [INSTR_W-1:0] imem_wdata,
  output logic               src_ren,
  output logic [REG_W-1:0]   src_raddr,
  input  logic [DATA_W-1:0]  src_rdata,
  output logic               dst_we,
  output logic [REG_W-1:0]   dst_waddr,
  output logic [DATA_W-1:0]  dst_wdata,
  output logic               busy
);
  logic [PC_W-1:0]           imem_raddr;
  logic [INSTR_W-1:0]        imem_rdata;
  logic [2:0][RIDX_W-1:0]    rf_raddr;
  logic [2:0][REG_W-1:0]     rf_rdata;
  logic                      rf_we;
  logic [RIDX_W-1:0]         rf_waddr;
  logic [REG_W-1:0]          rf_wdata;

  xfer_imem #(.DEPTH(IMEM_DEPTH), .AW(PC_W), .W(INSTR_W)) imem_i (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(imem_raddr), .rdata(imem_rdata));

  xfer_regfile #(.N(REG_N), .AW(RIDX_W), .W(REG_W), .PORTS(3)) rf_i (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata));

  xfer_seq #(.PC_W(PC_W)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .imem_raddr(imem_raddr), .imem_rdata(imem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .src_ren(src_ren), .src_raddr(src_raddr),
    .dst_we(dst_we), .dst_waddr(dst_waddr), .busy(busy));

  // returned word goes straight to the destination port
  assign dst_wdata = src_rdata;

  // R8
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> $past(src_ren));
  // R8
  read_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    src_ren |-> busy);
endmodule

// File: tb/xfer_engine_tb.sv
`timescale 1ns/1ps
module xfer_engine_tb_top;
  localparam int PC_W = 6;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic imem_we = 1'b0;
  logic [PC_W-1:0] imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic src_ren, dst_we, busy;
  logic [15:0] src_raddr, dst_waddr, dst_wdata;
  logic [15:0] src_rdata = '0;

  int cyc = 0, checks = 0, fails = 0;

  typedef struct { logic [15:0] addr; logic [15:0] data; int at; } exp_t;
  exp_t q[$];
  logic [31:0] prog [64];
  int plen;
  logic [15:0] mreg [16];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // source buffer model: registered read, contents = address ^ KEY
  always @(posedge clk) if (src_ren) src_rdata <= src_raddr ^ KEY;

  xfer_engine #(.IMEM_DEPTH(64), .PC_W(PC_W), .DATA_W(16)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .src_ren(src_ren), .src_raddr(src_raddr), .src_rdata(src_rdata),
    .dst_we(dst_we), .dst_waddr(dst_waddr), .dst_wdata(dst_wdata),
    .busy(busy));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input int rd,
      input int rs, input int rt, input logic [15:0] imm);
    return {op, rd[3:0], rs[3:0], rt[3:0], imm};
  endfunction

  // monitor: pops the scoreboard on every destination write
  always @(negedge clk) begin
    if (!rst && dst_we) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8/R9", "unexpected write addr", int'(dst_waddr), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(dst_waddr == e.addr, "R8/R9", "write addr", int'(dst_waddr), int'(e.addr));
        chk(dst_wdata == e.data, "R8/R9", "write data", int'(dst_wdata), int'(e.data));
        chk(cyc == e.at, "R4/R8/R9", "write cycle", cyc, e.at);
      end
    end
  end

  // R10: program loaded through the write port while idle
  task automatic load_prog();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = PC_W'(i); imem_wdata = prog[i];
    end
    @(negedge clk); imem_we = 1'b0;
  endtask

  task automatic pulse_start(output int ks);
    @(negedge clk); start = 1'b1; ks = cyc + 1;
    @(negedge clk); start = 0;
  endtask

  // driver: interprets the program from the requirements, pushes expectations
  task automatic model_run(input int ks, output int park);
    int f = ks;
    int pc = 0;
    park = -1;
    for (int s = 0; s < 64 && park < 0; s++) begin
      logic [31:0] w;
      logic [3:0] op; int rd, rs, rt; logic [15:0] imm, sa, da;
      w = prog[pc]; op = w[31:28]; rd = w[27:24]; rs = w[23:20]; rt = w[19:16];
      imm = w[15:0];
      case (op)
        4'b0000: if (imm == 0) park = f + 2; else f += 2 + int'(imm);
        4'b0010: begin if (rd != 0) mreg[rd] = imm; f += 2; end        // R6 R7
        4'b1000: begin
          sa = mreg[rs] + imm; da = mreg[rd] + imm;
          q.push_back('{addr: da, data: sa ^ KEY, at: f + 3});
          f += 3;
        end
        4'b1001: begin
          if (imm == 0) f += 2;
          else begin
            sa = mreg[rs]; da = mreg[rd];
            for (int i = 0; i < int'(imm); i++) begin
              q.push_back('{addr: da, data: sa ^ KEY, at: f + 3 + i});
              sa = sa + mreg[rt]; da = da + mreg[rt];
            end
            f += int'(imm) + 2;
          end
        end
        default: f += 2;                                              // R3
      endcase
      pc++;
    end
  endtask

  task automatic wait_to(input int p);
    while (cyc < p) @(negedge clk);
  endtask

  task automatic run_and_park(input string tag);
    int ks, park;
    pulse_start(ks);
    model_run(ks, park);
    chk(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    wait_to(park - 1);
    chk(busy == 1'b1, "R4", {tag, " busy before park"}, busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R5", {tag, " busy at park"}, busy, 0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && q.size() == 0, "R5", {tag, " parked, queue left"},
        q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mreg[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !src_ren && !dst_we, "R1", "reset outputs",
        {busy, src_ren, dst_we}, 0);
    repeat (5) @(negedge clk);
    chk(!busy, "R1", "idle without start", busy, 0);

    // P1: single offset move (R6, R8)
    prog[0] = mk(4'b0010, 1, 0, 0, 16'h0010);
    prog[1] = mk(4'b0010, 2, 0, 0, 16'h0200);
    prog[2] = mk(4'b1000, 2, 1, 0, 16'h0003);
    prog[3] = mk(4'b0000, 0, 0, 0, 16'h0000);
    plen = 4; load_prog(); run_and_park("P1");

    // P2: counted wait then strided repeat (R4, R9)
    prog[0] = mk(4'b0010, 3, 0, 0, 16'h0002);
    prog[1] = mk(4'b0010, 1, 0, 0, 16'h0040);
    prog[2] = mk(4'b0010, 2, 0, 0, 16'h0080);
    prog[3] = mk(4'b0000, 0, 0, 0, 16'h0003);
    prog[4] = mk(4'b1001, 2, 1, 3, 16'h0004);
    prog[5] = mk(4'b0000, 0, 0, 0, 16'h0000);
    plen = 6; load_prog(); run_and_park("P2");

    // P3: r0 load, zero repeat, unknown opcode, address wrap (R3, R7, R9)
    prog[0] = mk(4'b0010, 0, 0, 0, 16'h0099);
    prog[1] = mk(4'b1000, 0, 0, 0, 16'h0005);
    prog[2] = mk(4'b1001, 0, 0, 0, 16'h0000);
    prog[3] = mk(4'b0101, 1, 1, 1, 16'h1234);
    prog[4] = mk(4'b0010, 1, 0, 0, 16'hFFFF);
    prog[5] = mk(4'b0010, 4, 0, 0, 16'h0001);
    prog[6] = mk(4'b0010, 5, 0, 0, 16'h0300);
    prog[7] = mk(4'b1001, 5, 1, 4, 16'h0003);
    prog[8] = mk(4'b0000, 0, 0, 0, 16'h0000);
    plen = 9; load_prog(); run_and_park("P3");

    // P4: restart during a long wait (R2)
    prog[0] = mk(4'b0000, 0, 0, 0, 16'd100);
    prog[1] = mk(4'b0000, 0, 0, 0, 16'h0000);
    plen = 2; load_prog();
    begin
      int k1, park;
      pulse_start(k1);
      repeat (10) @(negedge clk);
      run_and_park("P4 restart");
      park = 0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule